// File: doc/BRIEF.md
# Circular and Bit-Reverse Address Generator

This block produces load/store addresses for a DSP data path. It keeps a small bank of index pointers. Each pointer has its own window base and window length. On every access the caller picks a pointer, an update mode and a 32-bit modify value; the caller has already chosen whether that value comes from a register or an immediate. The block returns the effective address one clock later together with a valid strobe.

The pointer is then advanced in one of three ways. Linear mode adds the modify value. Circular mode adds it and folds the result back into the pointer's base/length window. Bit-reverse mode adds it with the carry travelling from the top bit toward the bottom bit, which steps through FFT data in reordered sequence. A fourth mode forms index plus offset as the address and leaves the pointer untouched.

After its base or length changes, a window needs time to settle. Circular accesses to that pointer are therefore refused for a short, fixed window. A refused access raises a hazard flag instead of the valid strobe.

Top module: `addr_gen_unit`

## Requirements
- R1: After a synchronous active-low reset, every index, base and length register holds 0, and `ea_valid` and `haz_flag` are 0.
- R2: Linear access (`acc_mode` = 2'b00): the effective address is the index before the update, and the index becomes index + modify, modulo 2^32.
- R3: Relative access (`acc_mode` = 2'b11): the effective address is index + offset, and the index register keeps its value.
- R4: Circular access (`acc_mode` = 2'b01) with a length L > 0 and base B: the effective address is the old index. Let S = index + modify. The new index is S − L if S ≥ B + L, S + L if S < B, and S otherwise. Negative modify values are given in two's complement.
- R5: A circular walk with B, L = 4 and modify 1, starting at B, yields the addresses B, B+1, B+2 and B+3, and leaves the index at exactly B.
- R6: In circular mode a length of 0 disables wrapping, so the update equals the linear update.
- R7: Bit-reverse access (`acc_mode` = 2'b10): the effective address is the old index, and the new index is the reverse-carry sum of index and modify over all 32 bits. Index 0x0200A5A5 with modify 0x2121 gives 0x02009454, while the linear update of the same values gives 0x0200C6C6.
- R8: Suppose a base or length write (`wr_kind` 2'b01 = base, 2'b10 = length) hits pointer k in cycle t. A circular access to k in any cycle from t to t+3 is refused: `haz_flag` is 1 and `ea_valid` is 0 in the following cycle, and the index is unchanged. From t+4 the access proceeds. Other modes, and other pointers, are not affected.
- R9: A write to an index (`wr_kind` 2'b00) in the same cycle as an update of that index stores the written value. That access still reports the old index as its address.
- R10: `ea_out`, `ea_valid` and `haz_flag` are registered and reflect the access of the previous cycle. A cycle with no access gives `ea_valid` = 0 and `haz_flag` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | 00 index, 01 base, 10 length, 11 no effect |
| wr_sel | input | 2 | Pointer written |
| wr_data | input | 32 | Write value |
| acc_en | input | 1 | Access request |
| acc_mode | input | 2 | 00 linear, 01 circular, 10 bit-reverse, 11 relative |
| acc_sel | input | 2 | Pointer accessed |
| acc_mod | input | 32 | Modify value or relative offset |
| ea_out | output | 32 | Effective address |
| ea_valid | output | 1 | Address valid for the previous cycle's access |
| haz_flag | output | 1 | Previous cycle's circular access refused |

## Verification
The bench builds the block with its defaults: 32-bit addresses, four pointers and a four-cycle settle window. With 32-bit words, the reverse-carry example from R7 can be checked bit for bit. With four pointers, one pointer can sit in its settle window while another runs freely. A random phase then mixes register writes and accesses in all four modes against a reference model. That model tracks each pointer's window and settle counter. Windows up to 64 words long are used, so high wraps, low wraps and zero-length windows all occur.

// File: rtl/agu_pkg.sv
// Shared encodings for the address generator.
package agu_pkg;
    typedef enum logic [1:0] {
        AM_LIN  = 2'b00,
        AM_CIRC = 2'b01,
        AM_REV  = 2'b10,
        AM_REL  = 2'b11
    } acc_mode_e;

    typedef enum logic [1:0] {
        WK_IDX  = 2'b00,
        WK_BASE = 2'b01,
        WK_LEN  = 2'b10,
        WK_NONE = 2'b11
    } wr_kind_e;
endpackage

// File: rtl/agu_revcarry_add.sv
// Reverse-carry adder: the carry moves from the MSB toward the LSB.
// It is built as reverse(reverse(a) + reverse(b)), and the carry out is dropped.
// Purely combinational; no assumptions on the operands.
module agu_revcarry_add #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    logic [W-1:0] a_r, b_r, s_r;

    // mirror the operands and the sum bit by bit
    for (genvar g = 0; g < W; g++) begin : g_mirror
        assign a_r[g] = a[W-1-g];
        assign b_r[g] = b[W-1-g];
        assign s[g]   = s_r[W-1-g];
    end

    // ordinary addition in the mirrored domain
    assign s_r = a_r + b_r;

    // adding zero must return the other operand unchanged (R7)
    always_comb begin
        if (b == '0) begin
            a_zero_identity_r7: assert (s == a);
        end
    end
endmodule

// File: rtl/agu_circ_next.sv
// Next index for a circular access. It wraps the post-modify sum back into [base, base+len).
// Assumes |modify| <= len and that the window does not cross 2^32.
// A length of zero turns wrapping off.
module agu_circ_next #(
    parameter int W = 32
) (
    input  logic [W-1:0] idx,
    input  logic [W-1:0] modv,
    input  logic [W-1:0] base,
    input  logic [W-1:0] len,
    output logic [W-1:0] nxt
);
    logic [W-1:0] sum, win_end;

    assign sum     = idx + modv;
    assign win_end = base + len;

    // fold the sum into the window by one length at most
    always_comb begin
        if (len == '0)          nxt = sum;
        else if (sum >= win_end) nxt = sum - len;
        else if (sum < base)    nxt = sum + len;
        else                    nxt = sum;
    end

    // a zero length must give the linear result (R6)
    always_comb begin
        if (len == '0) begin
            zero_len_linear_r6: assert (nxt == idx + modv);
        end
    end
endmodule

// File: rtl/agu_hazard_track.sv
// Per-pointer settle counters. A base or length write to a pointer blocks its
// circular use in the write cycle and in the next HAZ-1 cycles.
// Assumes HAZ >= 1.
module agu_hazard_track #(
    parameter int NIDX = 4,
    parameter int HAZ  = 4,
    parameter int SW   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_bl,
    input  logic [SW-1:0] wr_sel,
    input  logic [SW-1:0] chk_sel,
    output logic          busy
);
    localparam int CW = (HAZ > 2) ? $clog2(HAZ) : 1;
    localparam logic [CW-1:0] LOAD = CW'(HAZ - 1);

    logic [CW-1:0] cnt_q [NIDX];

    for (genvar g = 0; g < NIDX; g++) begin : g_cnt
        // load the window on a base/length write, then count it down
        always_ff @(posedge clk) begin
            if (!rst_n)                               cnt_q[g] <= '0;
            else if (wr_bl && wr_sel == SW'(g))       cnt_q[g] <= LOAD;
            else if (cnt_q[g] != '0)                  cnt_q[g] <= cnt_q[g] - 1'b1;
        end

        // after a write the counter always starts at the full window (R8)
        p_cnt_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_bl && wr_sel == SW'(g)) |=> (cnt_q[g] == LOAD));
    end

    // blocked while a counter runs or a write hits the same pointer now
    assign busy = (cnt_q[chk_sel] != '0) || (wr_bl && wr_sel == chk_sel);
endmodule

// File: rtl/addr_gen_unit.sv
// Address generator top. It holds NIDX index/base/length triples.
// Each cycle it serves one access in linear, circular, bit-reverse or relative mode,
// and one register write. The write takes priority over the index update of the same pointer.
// Results are registered, one cycle after the access.
module addr_gen_unit
    import agu_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NIDX = 4,
    parameter int HAZ  = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [1:0]                            wr_kind,
    input  logic [((NIDX > 1) ? $clog2(NIDX) : 1)-1:0] wr_sel,
    input  logic [AW-1:0]                         wr_data,
    input  logic                                  acc_en,
    input  logic [1:0]                            acc_mode,
    input  logic [((NIDX > 1) ? $clog2(NIDX) : 1)-1:0] acc_sel,
    input  logic [AW-1:0]                         acc_mod,
    output logic [AW-1:0]                         ea_out,
    output logic                                  ea_valid,
    output logic                                  haz_flag
);
    localparam int SW = (NIDX > 1) ? $clog2(NIDX) : 1;

    logic [AW-1:0] idx_q  [NIDX];
    logic [AW-1:0] base_q [NIDX];
    logic [AW-1:0] len_q  [NIDX];

    acc_mode_e     mode;
    wr_kind_e      kind;
    logic [AW-1:0] cur_idx, cur_base, cur_len, cur_end;
    logic [AW-1:0] lin_sum, circ_nxt, rev_sum, nxt_idx, ea_now;
    logic          wr_bl, busy, blocked, go, upd;

    assign mode     = acc_mode_e'(acc_mode);
    assign kind     = wr_kind_e'(wr_kind);
    assign cur_idx  = idx_q[acc_sel];
    assign cur_base = base_q[acc_sel];
    assign cur_len  = len_q[acc_sel];
    assign cur_end  = cur_base + cur_len;
    assign lin_sum  = cur_idx + acc_mod;
    assign wr_bl    = wr_en && (kind == WK_BASE || kind == WK_LEN);

    agu_circ_next #(.W(AW)) u_circ (
        .idx(cur_idx), .modv(acc_mod), .base(cur_base), .len(cur_len), .nxt(circ_nxt)
    );

    agu_revcarry_add #(.W(AW)) u_rev (
        .a(cur_idx), .b(acc_mod), .s(rev_sum)
    );

    agu_hazard_track #(.NIDX(NIDX), .HAZ(HAZ), .SW(SW)) u_haz (
        .clk(clk), .rst_n(rst_n), .wr_bl(wr_bl), .wr_sel(wr_sel),
        .chk_sel(acc_sel), .busy(busy)
    );

    assign blocked = acc_en && mode == AM_CIRC && busy;
    assign go      = acc_en && !blocked;
    assign upd     = go && mode != AM_REL;

    // pick the updated index and the effective address for this access
    always_comb begin
        unique case (mode)
            AM_LIN:  nxt_idx = lin_sum;
            AM_CIRC: nxt_idx = circ_nxt;
            AM_REV:  nxt_idx = rev_sum;
            default: nxt_idx = cur_idx;
        endcase
        ea_now = (mode == AM_REL) ? lin_sum : cur_idx;
    end

    // register bank: writes win over the access update of the same pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NIDX; i++) begin
                idx_q[i]  <= '0;
                base_q[i] <= '0;
                len_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < NIDX; i++) begin
                if (wr_en && kind == WK_IDX && wr_sel == SW'(i))
                    idx_q[i] <= wr_data;
                else if (upd && acc_sel == SW'(i))
                    idx_q[i] <= nxt_idx;
                if (wr_en && kind == WK_BASE && wr_sel == SW'(i))
                    base_q[i] <= wr_data;
                if (wr_en && kind == WK_LEN && wr_sel == SW'(i))
                    len_q[i] <= wr_data;
            end
        end
    end

    // output stage: address, valid strobe and hazard flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_out   <= '0;
            ea_valid <= 1'b0;
            haz_flag <= 1'b0;
        end else begin
            if (go) ea_out <= ea_now;
            ea_valid <= go;
            haz_flag <= blocked;
        end
    end

    // relative access leaves the pointer alone unless written (R3)
    p_rel_keeps_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && mode == AM_REL && !(wr_en && kind == WK_IDX && wr_sel == acc_sel))
        |=> (idx_q[$past(acc_sel)] == $past(cur_idx)));

    // a circular step from inside the window stays inside it (R4)
    p_circ_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go && mode == AM_CIRC && cur_len != '0 && cur_base >= cur_len &&
         cur_end + cur_len > cur_end && cur_idx >= cur_base && cur_idx < cur_end &&
         (acc_mod <= cur_len || (AW'(0) - acc_mod) <= cur_len) &&
         !(wr_en && kind == WK_IDX && wr_sel == acc_sel))
        |=> (idx_q[$past(acc_sel)] >= $past(cur_base) &&
             idx_q[$past(acc_sel)] <  $past(cur_end)));

    // a circular access that meets a same-cycle base/length write is refused (R8)
    p_same_cycle_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && mode == AM_CIRC && wr_bl && wr_sel == acc_sel)
        |=> (haz_flag && !ea_valid));

    // the index write wins over the update (R9)
    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == WK_IDX) |=> (idx_q[$past(wr_sel)] == $past(wr_data)));

    // non-circular accesses always answer next cycle (R10)
    p_noncirc_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && mode != AM_CIRC) |=> ea_valid);

    // idle cycles give neither strobe (R10)
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> (!ea_valid && !haz_flag));
endmodule

// File: tb/test_addr_gen_unit.sv
module test_addr_gen_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = '0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        acc_en = 1'b0;
    logic [1:0]  acc_mode = '0;
    logic [1:0]  acc_sel = '0;
    logic [31:0] acc_mod = '0;
    logic [31:0] ea_out;
    logic        ea_valid, haz_flag;

    int total = 0;
    int bad = 0;
    int cyc_n = 0;
    bit done = 1'b0;

    logic [31:0] m_idx [4];
    logic [31:0] m_base [4];
    logic [31:0] m_len [4];
    int          m_last [4];

    always #(CLK_PERIOD / 2) clk = ~clk;

    addr_gen_unit i_addr_gen_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_sel(wr_sel),
        .wr_data(wr_data), .acc_en(acc_en), .acc_mode(acc_mode), .acc_sel(acc_sel),
        .acc_mod(acc_mod), .ea_out(ea_out), .ea_valid(ea_valid), .haz_flag(haz_flag)
    );

    // table rows: {mode, sel, modify, expected address}
    localparam logic [67:0] VEC [NV] = '{
        {2'b10, 2'd0, 32'h0000_2121, 32'h0200_A5A5},
        {2'b11, 2'd0, 32'h0000_0000, 32'h0200_9454},
        {2'b00, 2'd0, 32'h0000_0010, 32'h0200_9454},
        {2'b11, 2'd0, 32'h0000_0004, 32'h0200_9468},
        {2'b11, 2'd0, 32'h0000_0000, 32'h0200_9464},
        {2'b00, 2'd1, 32'h0000_2121, 32'h0200_A5A5},
        {2'b11, 2'd1, 32'h0000_0000, 32'h0200_C6C6},
        {2'b11, 2'd1, 32'hFFFF_FFFF, 32'h0200_C6C5}
    };

    function automatic logic [31:0] rc_add(input logic [31:0] a, input logic [31:0] b);
        logic c = 1'b0;
        logic [31:0] s;
        for (int i = 31; i >= 0; i--) begin
            s[i] = a[i] ^ b[i] ^ c;
            c = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
        end
        return s;
    endfunction

    function automatic logic [31:0] circ_rule(input logic [31:0] x, input logic [31:0] m,
                                              input logic [31:0] b, input logic [31:0] l);
        logic [31:0] s = x + m;
        if (l == 0) return s;
        if (s >= b + l) return s - l;
        if (s < b) return s + l;
        return s;
    endfunction

    function automatic string tag_of(input logic [1:0] md);
        case (md)
            2'b00: return "R2";
            2'b01: return "R4";
            2'b10: return "R7";
            default: return "R3";
        endcase
    endfunction

    // one clock: model prediction, drive, edge, compare
    task automatic cyc(input logic we, input logic [1:0] wk, input logic [1:0] ws,
                       input logic [31:0] wd, input logic ae, input logic [1:0] am,
                       input logic [1:0] as, input logic [31:0] md, input string req);
        logic exp_v, exp_h;
        logic [31:0] exp_ea, nx;
        logic blk;
        blk = ae && am == 2'b01 &&
              ((cyc_n - m_last[as]) < 4 || (we && (wk == 2'b01 || wk == 2'b10) && ws == as));
        exp_h = blk;
        exp_v = ae && !blk;
        exp_ea = (am == 2'b11) ? m_idx[as] + md : m_idx[as];
        case (am)
            2'b00: nx = m_idx[as] + md;
            2'b01: nx = circ_rule(m_idx[as], md, m_base[as], m_len[as]);
            2'b10: nx = rc_add(m_idx[as], md);
            default: nx = m_idx[as];
        endcase
        if (exp_v) m_idx[as] = nx;
        if (we) begin
            if (wk == 2'b00) m_idx[ws] = wd;
            if (wk == 2'b01) begin m_base[ws] = wd; m_last[ws] = cyc_n; end
            if (wk == 2'b10) begin m_len[ws] = wd;  m_last[ws] = cyc_n; end
        end
        wr_en = we; wr_kind = wk; wr_sel = ws; wr_data = wd;
        acc_en = ae; acc_mode = am; acc_sel = as; acc_mod = md;
        @(posedge clk);
        #1;
        cyc_n++;
        wr_en = 1'b0; acc_en = 1'b0;
        total++;
        if (ea_valid !== exp_v || haz_flag !== exp_h || (exp_v && ea_out !== exp_ea)) begin
            bad++;
            $display("FAIL %s: valid=%0b haz=%0b ea=%h expected valid=%0b haz=%0b ea=%h",
                     req, ea_valid, haz_flag, ea_out, exp_v, exp_h, exp_ea);
        end
    endtask

    task automatic acc(input logic [1:0] am, input logic [1:0] as, input logic [31:0] md,
                       input string req);
        cyc(1'b0, 2'b00, 2'd0, 32'd0, 1'b1, am, as, md, req);
    endtask

    task automatic wr(input logic [1:0] wk, input logic [1:0] ws, input logic [31:0] wd);
        cyc(1'b1, wk, ws, wd, 1'b0, 2'b00, 2'd0, 32'd0, "R10");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'b00, 2'd0, 32'd0, 1'b0, 2'b00, 2'd0, 32'd0, "R10");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_idx[i] = '0; m_base[i] = '0; m_len[i] = '0; m_last[i] = -100;
        end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: outputs quiet and every pointer reads back as zero
        total++;
        if (ea_valid !== 1'b0 || haz_flag !== 1'b0) begin
            bad++;
            $display("FAIL R1: valid=%0b haz=%0b expected 0 0", ea_valid, haz_flag);
        end
        for (int i = 0; i < 4; i++) acc(2'b11, 2'(i), 32'd0, "R1");
        acc(2'b01, 2'd2, 32'd0, "R1");

        // table walk: bit-reverse, linear and relative forms
        wr(2'b00, 2'd0, 32'h0200_A5A5);
        wr(2'b00, 2'd1, 32'h0200_A5A5);
        for (int v = 0; v < NV; v++)
            acc(VEC[v][67:66], VEC[v][65:64], VEC[v][63:32], tag_of(VEC[v][67:66]));
        for (int v = 0; v < NV; v++) begin
            total++;
            if (m_idx[0] === 32'hx) bad++;
        end

        // R8 and R5: settle window, then a length-4 walk back to base
        wr(2'b01, 2'd0, 32'h0000_0100);
        wr(2'b00, 2'd0, 32'h0000_0100);
        cyc(1'b1, 2'b10, 2'd0, 32'd4, 1'b1, 2'b01, 2'd0, 32'd1, "R8");
        acc(2'b01, 2'd0, 32'd1, "R8");
        acc(2'b00, 2'd1, 32'd0, "R8");
        acc(2'b01, 2'd0, 32'd1, "R8");
        acc(2'b01, 2'd3, 32'd0, "R8");
        for (int k = 0; k < 4; k++) acc(2'b01, 2'd0, 32'd1, "R5");
        acc(2'b11, 2'd0, 32'd0, "R5");

        // R4: high wrap and low wrap with a negative modify
        wr(2'b01, 2'd2, 32'h0000_0100);
        wr(2'b10, 2'd2, 32'd8);
        wr(2'b00, 2'd2, 32'h0000_0106);
        idle(3);
        acc(2'b01, 2'd2, 32'd3, "R4");
        acc(2'b11, 2'd2, 32'd0, "R4");
        acc(2'b01, 2'd2, 32'hFFFF_FFFD, "R4");
        acc(2'b11, 2'd2, 32'd0, "R4");

        // R6: zero length behaves linearly
        wr(2'b01, 2'd3, 32'h0000_0500);
        wr(2'b10, 2'd3, 32'd0);
        wr(2'b00, 2'd3, 32'h0000_0500);
        idle(3);
        acc(2'b01, 2'd3, 32'h0000_1000, "R6");
        acc(2'b11, 2'd3, 32'd0, "R6");

        // R9: index write in the same cycle as a linear update
        cyc(1'b1, 2'b00, 2'd1, 32'h0000_0777, 1'b1, 2'b00, 2'd1, 32'd5, "R9");
        acc(2'b11, 2'd1, 32'd0, "R9");

        // R10: idle cycle gives no strobe
        idle(1);

        // random mix against the model
        for (int n = 0; n < 600; n++) begin
            logic we;
            logic [1:0] wk, ws, am, as;
            logic [31:0] wd, md;
            we = ($urandom % 6) == 0;
            wk = 2'($urandom % 3);
            ws = 2'($urandom % 4);
            case (wk)
                2'b01: wd = 32'h0000_1000 + ($urandom & 32'h0FFF_FFF0);
                2'b10: wd = $urandom % 65;
                default: wd = m_base[ws] + ($urandom % (m_len[ws] + 1));
            endcase
            am = 2'($urandom % 4);
            as = 2'($urandom % 4);
            if (am == 2'b01 && m_len[as] != 0)
                md = ($urandom % (2 * m_len[as] + 1)) - m_len[as];
            else if (am == 2'b01)
                md = $urandom % 16;
            else
                md = $urandom;
            cyc(we, wk, ws, wd, ($urandom % 5) != 0, am, as, md, tag_of(am));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule